// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between the clock sources of a board-level clock generator and its output pins. It turns groups of clock outputs on and off without ever producing a runt pulse. Four groups are handled. The processor group and the peripheral-bus group can each be stopped by an active-low pin. The free-running bus clock and the miscellaneous outputs can only be switched through their enable bits.

Every output is the logical AND of its source clock and a gating flop. That flop is clocked on the falling edge of the same source. Its value can therefore change only while the source is low, so every high phase that appears at an output is complete.

A stop pin first passes through a two-flop synchronizer clocked on the rising edge of the free-running bus source. The result is then taken up by the target group's falling-edge gating flop. When the mode strap is high, both stop pins are ignored. Register enable bits are applied directly at the next falling edge of each output's own source.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low every output is low. After reset, an output runs exactly when its enable bit is 1 and no active stop pin applies to it. A change of an enable bit takes effect at the next falling edge of that output's own source clock.
- R2: With `mode_strap` = 0 and `cpu_stop_n` = 0, every processor-group output is held low. The bus, free-running bus and miscellaneous outputs keep running.
- R3: With `mode_strap` = 0 and `pci_stop_n` = 0, every peripheral-bus output is held low. The processor and miscellaneous outputs keep running.
- R4: `pci_stop_n` never affects `pcif_clk_o`. That output stops only when `pcif_en` = 0.
- R5: With `mode_strap` = 1, both stop pins are ignored and outputs follow their enable bits alone. A pin change is synchronized on two rising edges of `pci_src_clk` and then applied at the next falling edge of the target source.
- R6: A gated output is never high while its source is low. Every high pulse on a gated output lasts the full high phase of its source, including the last pulse before a stop and the first pulse after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | 1 = stop pins ignored, 0 = stop pins active |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| pci_stop_n | input | 1 | Active-low stop request for the bus group |
| cpu_src_clk | input | 1 | Source clock of the processor group |
| pci_src_clk | input | 1 | Free-running bus source clock, also the synchronizer reference |
| misc_src_clk | input | N_MISC | One source clock per miscellaneous output |
| cpu_en | input | N_CPU | Per-output enables, processor group |
| pci_en | input | N_PCI | Per-output enables, bus group |
| pcif_en | input | 1 | Enable of the free-running bus output |
| misc_en | input | N_MISC | Per-output enables, miscellaneous outputs |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| pcif_clk_o | output | 1 | Gated free-running bus clock |
| misc_clk_o | output | N_MISC | Gated miscellaneous clocks |

## Verification
The bench builds the block with its defaults: four processor outputs, six bus outputs and two miscellaneous outputs. The sources run at unrelated periods of 3, 5, 7 and 4 ns, so falling edges of the target domains drift against the synchronizer's rising edges. Because each processor and bus output has its own enable bit, sparse enable masks can be checked per output against pin stops. With two miscellaneous outputs on separate sources, it can be shown that neither stop pin reaches a clock outside its group. Pulse widths on one processor and one bus output are measured across every stop and restart.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;
    // Two-stage synchronizer state for a stop request.
    typedef struct packed {
        logic meta;
        logic held;
    } sync_pair_t;

    // A stop request reads as "allowed to run" until the first edges after reset.
    localparam logic ALLOW_AT_RESET = 1'b1;
endpackage

// File: rtl/clk_stop_sync.sv
`timescale 1ns/1ps
module clk_stop_sync
    import clk_stop_gate_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic stop_n,
    input  logic bypass,
    output logic allow
);
    sync_pair_t st_d;
    sync_pair_t st_q;

    always_comb begin
        st_d.meta = stop_n | bypass;
        st_d.held = st_q.meta;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: ALLOW_AT_RESET, held: ALLOW_AT_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign allow = st_q.held;
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
    parameter int N = 1
) (
    input  logic         src_clk,
    input  logic         rst_n,
    input  logic [N-1:0] en,
    input  logic         allow,
    output logic [N-1:0] clk_o
);
    typedef struct packed {
        logic [N-1:0] gate;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d.gate = en & {N{allow}};
    end

    // Falling-edge update: the gate only moves while the source is low.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_and
        assign clk_o[i] = src_clk & bank_q.gate[i];
    end
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter int N_CPU  = 4,
    parameter int N_PCI  = 6,
    parameter int N_MISC = 2
) (
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              cpu_src_clk,
    input  logic              pci_src_clk,
    input  logic [N_MISC-1:0] misc_src_clk,
    input  logic [N_CPU-1:0]  cpu_en,
    input  logic [N_PCI-1:0]  pci_en,
    input  logic              pcif_en,
    input  logic [N_MISC-1:0] misc_en,
    output logic [N_CPU-1:0]  cpu_clk_o,
    output logic [N_PCI-1:0]  pci_clk_o,
    output logic              pcif_clk_o,
    output logic [N_MISC-1:0] misc_clk_o
);
    logic cpu_allow;
    logic pci_allow;

    clk_stop_sync u_cpu_sync (
        .ref_clk (pci_src_clk),
        .rst_n   (rst_n),
        .stop_n  (cpu_stop_n),
        .bypass  (mode_strap),
        .allow   (cpu_allow)
    );

    clk_stop_sync u_pci_sync (
        .ref_clk (pci_src_clk),
        .rst_n   (rst_n),
        .stop_n  (pci_stop_n),
        .bypass  (mode_strap),
        .allow   (pci_allow)
    );

    clk_gate_bank #(.N(N_CPU)) u_cpu_bank (
        .src_clk (cpu_src_clk),
        .rst_n   (rst_n),
        .en      (cpu_en),
        .allow   (cpu_allow),
        .clk_o   (cpu_clk_o)
    );

    clk_gate_bank #(.N(N_PCI)) u_pci_bank (
        .src_clk (pci_src_clk),
        .rst_n   (rst_n),
        .en      (pci_en),
        .allow   (pci_allow),
        .clk_o   (pci_clk_o)
    );

    clk_gate_bank #(.N(1)) u_pcif_bank (
        .src_clk (pci_src_clk),
        .rst_n   (rst_n),
        .en      (pcif_en),
        .allow   (1'b1),
        .clk_o   (pcif_clk_o)
    );

    for (genvar m = 0; m < N_MISC; m++) begin : g_misc
        clk_gate_bank #(.N(1)) u_misc_bank (
            .src_clk (misc_src_clk[m]),
            .rst_n   (rst_n),
            .en      (misc_en[m]),
            .allow   (1'b1),
            .clk_o   (misc_clk_o[m])
        );
    end
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
    parameter int N_CPU  = 4,
    parameter int N_PCI  = 6,
    parameter int N_MISC = 2
) (
    input logic              rst_n,
    input logic              mode_strap,
    input logic              cpu_src_clk,
    input logic              pci_src_clk,
    input logic [N_MISC-1:0] misc_src_clk,
    input logic [N_CPU-1:0]  cpu_en,
    input logic              pcif_en,
    input logic [N_CPU-1:0]  cpu_clk_o,
    input logic [N_PCI-1:0]  pci_clk_o,
    input logic              pcif_clk_o,
    input logic [N_MISC-1:0] misc_clk_o,
    input logic              cpu_allow,
    input logic              pci_allow
);
    // R1: reset forces every output low
    always_comb begin
        if (rst_n === 1'b0) begin
            a_r1_reset_low: assert (cpu_clk_o == '0 && pci_clk_o == '0 &&
                                    pcif_clk_o == 1'b0 && misc_clk_o == '0)
                else $error("outputs not low in reset");
        end
    end

    // R6: no output high while its source is low
    always_comb begin
        if (rst_n === 1'b1) begin
            a_r6_no_high_when_src_low: assert (
                (cpu_clk_o & ~{N_CPU{cpu_src_clk}}) == '0 &&
                (pci_clk_o & ~{N_PCI{pci_src_clk}}) == '0 &&
                (pcif_clk_o & ~pci_src_clk) == 1'b0 &&
                (misc_clk_o & ~misc_src_clk) == '0)
                else $error("gated output high while source low");
        end
    end

    // R2: a synchronized processor stop leaves the next high phase empty
    a_r2_cpu_stop_low: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
        !cpu_allow |=> cpu_clk_o == '0);

    // R1: when allowed, the next high phase follows the enables
    a_r1_cpu_follow_en: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
        cpu_allow |=> cpu_clk_o == $past(cpu_en));

    // R3: a synchronized bus stop leaves the next high phase empty
    a_r3_pci_stop_low: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
        !pci_allow |=> pci_clk_o == '0);

    // R4: free-running bus output follows its own enable only
    a_r4_pcif_follows_en: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
        pcif_en |=> pcif_clk_o);

    a_r4_pcif_off_when_disabled: assert property (@(negedge pci_src_clk) disable iff (!rst_n)
        !pcif_en |=> !pcif_clk_o);

    // R5: mode strap high keeps both synchronized requests at "allow"
    a_r5_mode_bypass: assert property (@(posedge pci_src_clk) disable iff (!rst_n)
        (mode_strap && $past(mode_strap)) |=> (cpu_allow && pci_allow));
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
    .N_CPU  (N_CPU),
    .N_PCI  (N_PCI),
    .N_MISC (N_MISC)
) u_chk (
    .rst_n        (rst_n),
    .mode_strap   (mode_strap),
    .cpu_src_clk  (cpu_src_clk),
    .pci_src_clk  (pci_src_clk),
    .misc_src_clk (misc_src_clk),
    .cpu_en       (cpu_en),
    .pcif_en      (pcif_en),
    .cpu_clk_o    (cpu_clk_o),
    .pci_clk_o    (pci_clk_o),
    .pcif_clk_o   (pcif_clk_o),
    .misc_clk_o   (misc_clk_o),
    .cpu_allow    (cpu_allow),
    .pci_allow    (pci_allow)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
    localparam int N_CPU  = 4;
    localparam int N_PCI  = 6;
    localparam int N_MISC = 2;

    logic              rst_n;
    logic              mode_strap;
    logic              cpu_stop_n;
    logic              pci_stop_n;
    logic              cpu_src_clk;
    logic              pci_src_clk;
    logic [N_MISC-1:0] misc_src_clk;
    logic [N_CPU-1:0]  cpu_en;
    logic [N_PCI-1:0]  pci_en;
    logic              pcif_en;
    logic [N_MISC-1:0] misc_en;
    logic [N_CPU-1:0]  cpu_clk_o;
    logic [N_PCI-1:0]  pci_clk_o;
    logic              pcif_clk_o;
    logic [N_MISC-1:0] misc_clk_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    clk_stop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_MISC(N_MISC)) u0 (
        .rst_n        (rst_n),
        .mode_strap   (mode_strap),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .cpu_src_clk  (cpu_src_clk),
        .pci_src_clk  (pci_src_clk),
        .misc_src_clk (misc_src_clk),
        .cpu_en       (cpu_en),
        .pci_en       (pci_en),
        .pcif_en      (pcif_en),
        .misc_en      (misc_en),
        .cpu_clk_o    (cpu_clk_o),
        .pci_clk_o    (pci_clk_o),
        .pcif_clk_o   (pcif_clk_o),
        .misc_clk_o   (misc_clk_o)
    );

    // 200 MHz bus source; other sources at unrelated periods
    initial pci_src_clk = 1'b0;
    always #2.5 pci_src_clk = ~pci_src_clk;
    initial cpu_src_clk = 1'b0;
    always #1.5 cpu_src_clk = ~cpu_src_clk;
    initial misc_src_clk[0] = 1'b0;
    always #3.5 misc_src_clk[0] = ~misc_src_clk[0];
    initial misc_src_clk[1] = 1'b0;
    always #2.0 misc_src_clk[1] = ~misc_src_clk[1];

    typedef struct {
        string             req;
        logic [N_CPU-1:0]  cpu;
        logic [N_PCI-1:0]  pci;
        logic              pcif;
        logic [N_MISC-1:0] misc;
    } exp_t;

    exp_t exp_q[$];

    task automatic tally(input string req, input string grp,
                         input logic [7:0] a_and, input logic [7:0] a_or,
                         input logic [7:0] expv);
        checks++;
        if (a_and !== expv || a_or !== expv) begin
            errors++;
            $display("FAIL %s %s running-mask and=%b or=%b expected %b",
                     req, grp, a_and, a_or, expv);
        end
    endtask

    // Monitor: samples each output in mid high phase over several cycles
    initial begin
        forever begin
            exp_t e;
            logic [7:0] g_and;
            logic [7:0] g_or;
            wait (exp_q.size() > 0);
            e = exp_q[0];

            g_and = '1; g_or = '0;
            repeat (4) begin
                @(posedge cpu_src_clk); #0.75;
                g_and &= 8'(cpu_clk_o); g_or |= 8'(cpu_clk_o);
            end
            tally(e.req, "cpu", g_and & 8'hF, g_or, 8'(e.cpu));

            g_and = '1; g_or = '0;
            repeat (4) begin
                @(posedge pci_src_clk); #1.25;
                g_and &= 8'({pcif_clk_o, pci_clk_o}); g_or |= 8'({pcif_clk_o, pci_clk_o});
            end
            tally(e.req, "pci", g_and & 8'h3F, g_or & 8'h3F, 8'(e.pci));
            tally(e.req, "pcif", 8'(g_and[6]), 8'(g_or[6]), 8'(e.pcif));

            g_and = '1; g_or = '0;
            repeat (4) begin
                @(posedge misc_src_clk[0]); #1.75;
                g_and[0] &= misc_clk_o[0]; g_or[0] |= misc_clk_o[0];
            end
            repeat (4) begin
                @(posedge misc_src_clk[1]); #1.0;
                g_and[1] &= misc_clk_o[1]; g_or[1] |= misc_clk_o[1];
            end
            tally(e.req, "misc", g_and & 8'h3, g_or & 8'h3, 8'(e.misc));

            void'(exp_q.pop_front());
        end
    end

    // Pulse-width monitors for R6
    int short_pci = 0;
    int short_cpu = 0;
    int pulses_pci = 0;
    int pulses_cpu = 0;
    initial begin
        forever begin
            realtime t0;
            @(posedge pci_clk_o[0]); t0 = $realtime;
            @(negedge pci_clk_o[0]);
            pulses_pci++;
            if ($realtime - t0 < 2.45) short_pci++;
        end
    end
    initial begin
        forever begin
            realtime t0;
            @(posedge cpu_clk_o[0]); t0 = $realtime;
            @(negedge cpu_clk_o[0]);
            pulses_cpu++;
            if ($realtime - t0 < 1.45) short_cpu++;
        end
    end

    // Driver: apply a setting, let it settle, push the expectation
    task automatic step(input string req, input logic mode, input logic cs_n,
                        input logic ps_n, input logic [N_CPU-1:0] ce,
                        input logic [N_PCI-1:0] pe, input logic fe,
                        input logic [N_MISC-1:0] me,
                        input logic [N_CPU-1:0] x_cpu, input logic [N_PCI-1:0] x_pci,
                        input logic x_pcif, input logic [N_MISC-1:0] x_misc);
        exp_t e;
        @(posedge pci_src_clk); #1.2;
        mode_strap = mode; cpu_stop_n = cs_n; pci_stop_n = ps_n;
        cpu_en = ce; pci_en = pe; pcif_en = fe; misc_en = me;
        repeat (8) @(posedge pci_src_clk);
        e.req = req; e.cpu = x_cpu; e.pci = x_pci; e.pcif = x_pcif; e.misc = x_misc;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    initial begin
        rst_n = 1'b0; mode_strap = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        cpu_en = '1; pci_en = '1; pcif_en = 1'b1; misc_en = '1;
        #20;
        // R1: reset state
        checks++;
        if (cpu_clk_o !== '0 || pci_clk_o !== '0 || pcif_clk_o !== 1'b0 || misc_clk_o !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs cpu=%b pci=%b pcif=%b misc=%b expected all 0",
                     cpu_clk_o, pci_clk_o, pcif_clk_o, misc_clk_o);
        end
        #10.2 rst_n = 1'b1;

        //     req    mode cs ps  cpu_en   pci_en      pcif misc   | expected
        step("R1", 0, 1, 1, 4'hF,    6'h3F,      1, 2'b11, 4'hF,    6'h3F,      1, 2'b11);
        step("R1", 0, 1, 1, 4'b0101, 6'h3F,      1, 2'b11, 4'b0101, 6'h3F,      1, 2'b11);
        step("R2", 0, 0, 1, 4'hF,    6'h3F,      1, 2'b11, 4'h0,    6'h3F,      1, 2'b11);
        step("R3", 0, 0, 0, 4'hF,    6'h3F,      1, 2'b11, 4'h0,    6'h00,      1, 2'b11);
        step("R3", 0, 1, 0, 4'hF,    6'h3F,      1, 2'b11, 4'hF,    6'h00,      1, 2'b11);
        step("R4", 0, 1, 0, 4'hF,    6'h3F,      0, 2'b11, 4'hF,    6'h00,      0, 2'b11);
        step("R4", 0, 1, 1, 4'hF,    6'b100110,  0, 2'b11, 4'hF,    6'b100110,  0, 2'b11);
        step("R5", 1, 0, 0, 4'hF,    6'h3F,      1, 2'b11, 4'hF,    6'h3F,      1, 2'b11);
        step("R5", 1, 0, 0, 4'b1010, 6'b010101,  1, 2'b01, 4'b1010, 6'b010101,  1, 2'b01);
        step("R2", 0, 0, 1, 4'hF,    6'h3F,      1, 2'b10, 4'h0,    6'h3F,      1, 2'b10);
        step("R1", 0, 1, 1, 4'hF,    6'h3F,      1, 2'b11, 4'hF,    6'h3F,      1, 2'b11);

        // R6: every pulse seen was a full high phase, across stops and restarts
        checks++;
        if (short_pci != 0 || pulses_pci == 0) begin
            errors++;
            $display("FAIL R6 bus short pulses=%0d of %0d expected 0 short", short_pci, pulses_pci);
        end
        checks++;
        if (short_cpu != 0 || pulses_cpu == 0) begin
            errors++;
            $display("FAIL R6 cpu short pulses=%0d of %0d expected 0 short", short_cpu, pulses_cpu);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule